// File: doc/BRIEF.md
# Indirect-branch density monitor

This block watches the instruction stream at the retirement stage of a superscalar core. It looks for control-flow hijacking that chains many short code fragments, each ending in an indirect branch. Every cycle up to `RET_W` instructions retire, in program order. Each one carries a valid flag and a flag that is set when the instruction is a return, an indirect jump or an indirect call. The monitor keeps the last `WIN_W` such flags as a shift-register history. For each retiring instruction it forms the history as that instruction sees it, counts the set bits and compares the count with a programmable limit. When the count is above the limit, it requests an exception for that instruction.

Each snapshot is checked on its own, so `RET_W` comparisons happen in parallel within the same cycle. Retirement is never stalled. Only the oldest offending instruction is reported, and the younger ones in the same group are marked squashed. The history and the limit can both be read and written, so privileged software can save and restore them across context switches. A typical setup is a 32-entry window with a limit of 10.

Top module: `ib_density_mon`

## Requirements
- R1: After reset the history `win_o` is all zeros, the limit `thr_o` equals `THR_RST` (default 10), and no exception or squash is signalled.
- R2: Each valid retire slot shifts its indirect-branch bit (1 = indirect branch) into bit 0 of the history, and bit `WIN_W-1` drops out. Slots enter in slot order, so retiring bits b0, b1, b2 in slots 0, 1, 2 leaves `win_o[2:0] = {b0,b1,b2}` on the next cycle.
- R3: A retire slot with its valid flag low neither shifts the history nor raises an exception or squash bit.
- R4: Valid slot k is checked against the history after the bits of slots 0..k have been shifted in. It is flagged when that history's set-bit count is strictly greater than `thr_o`.
- R5: `exc_vec_o` is one-hot on the oldest flagged slot, or zero when no slot is flagged. `exc_valid_o` is high exactly when a slot is flagged, and `exc_slot_o` gives the index of that slot. `squash_o` is set for every valid slot younger than the flagged slot and is zero otherwise.
- R6: When an exception is signalled, the history advances only through the flagged slot. Squashed slots do not enter it.
- R7: When `win_we_i` is high, `win_wdata_i` is loaded into the history on the next edge. This load replaces any retire update in the same cycle.
- R8: When `thr_we_i` is high, `thr_wdata_i` becomes the limit from the next cycle on.
- R9: Exception, slot and squash outputs reflect the current cycle's retire inputs combinationally, in the same cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ret_valid_i | input | RET_W | Retire slot valid flags, slot 0 oldest |
| ret_ib_i | input | RET_W | Indirect-branch flag per retire slot |
| win_we_i | input | 1 | History register write enable |
| win_wdata_i | input | WIN_W | History write data |
| thr_we_i | input | 1 | Limit register write enable |
| thr_wdata_i | input | CNT_W | Limit write data |
| win_o | output | WIN_W | Current history (register read) |
| thr_o | output | CNT_W | Current limit (register read) |
| exc_valid_o | output | 1 | Exception request this cycle |
| exc_vec_o | output | RET_W | One-hot oldest flagged slot |
| exc_slot_o | output | SLOT_W | Index of the flagged slot |
| squash_o | output | RET_W | Younger valid slots squashed by the exception |

## Verification
Some properties are checked by assertions on every cycle. These are: the exception vector is one-hot, stays within the valid slots and agrees with the exception flag and the slot index. Squash bits appear only behind a flagged slot. An idle cycle leaves the history unchanged, a write always wins, and after an exception the flagged slot's bit becomes the newest history bit. Some behaviour only the bench scenarios can show. These are: the exact strict-greater comparison against the limit at counts just below, at and above it, the bit that is shifted out at the top of the window, the effect of holes in the valid mask, and limit reprogramming. The bench does this by sweeping preloaded histories against every valid mask and every branch-flag pattern.

// File: rtl/ibd_pkg.sv
package ibd_pkg;
  function automatic int unsigned clog2_min1(int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/ibd_snap_chain.sv
module ibd_snap_chain #(
  parameter int unsigned RET_W = 3,
  parameter int unsigned WIN_W = 32
) (
  input  logic [WIN_W-1:0]            win_i,
  input  logic [RET_W-1:0]            valid_i,
  input  logic [RET_W-1:0]            ib_i,
  output logic [RET_W:0][WIN_W-1:0]   snap_o
);
  assign snap_o[0] = win_i;

  for (genvar k = 0; k < RET_W; k++) begin : g_stage
    assign snap_o[k+1] = valid_i[k] ? {snap_o[k][WIN_W-2:0], ib_i[k]} : snap_o[k];
  end
endmodule

// File: rtl/ibd_popcmp.sv
module ibd_popcmp #(
  parameter int unsigned WIN_W = 32,
  parameter int unsigned CNT_W = 6
) (
  input  logic [WIN_W-1:0] win_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             over_o
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < int'(WIN_W); i++) begin
      cnt = cnt + CNT_W'(win_i[i]);
    end
  end

  assign over_o = (cnt > thr_i);
endmodule

// File: rtl/ibd_prio.sv
module ibd_prio #(
  parameter int unsigned RET_W  = 3,
  parameter int unsigned SLOT_W = 2
) (
  input  logic [RET_W-1:0]  hit_i,
  input  logic [RET_W-1:0]  valid_i,
  output logic              exc_valid_o,
  output logic [RET_W-1:0]  exc_vec_o,
  output logic [SLOT_W-1:0] exc_slot_o,
  output logic [RET_W-1:0]  squash_o
);
  always_comb begin
    exc_valid_o = 1'b0;
    exc_vec_o   = '0;
    exc_slot_o  = '0;
    squash_o    = '0;
    for (int k = 0; k < int'(RET_W); k++) begin
      if (exc_valid_o) begin
        squash_o[k] = valid_i[k];
      end else if (hit_i[k]) begin
        exc_valid_o  = 1'b1;
        exc_vec_o[k] = 1'b1;
        exc_slot_o   = SLOT_W'(k);
      end
    end
  end
endmodule

// File: rtl/ib_density_mon.sv
module ib_density_mon #(
  parameter int unsigned RET_W   = 3,
  parameter int unsigned WIN_W   = 32,
  parameter int unsigned CNT_W   = $clog2(WIN_W + 1),
  parameter int unsigned SLOT_W  = ibd_pkg::clog2_min1(RET_W),
  parameter int unsigned THR_RST = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RET_W-1:0]  ret_valid_i,
  input  logic [RET_W-1:0]  ret_ib_i,
  input  logic              win_we_i,
  input  logic [WIN_W-1:0]  win_wdata_i,
  input  logic              thr_we_i,
  input  logic [CNT_W-1:0]  thr_wdata_i,
  output logic [WIN_W-1:0]  win_o,
  output logic [CNT_W-1:0]  thr_o,
  output logic              exc_valid_o,
  output logic [RET_W-1:0]  exc_vec_o,
  output logic [SLOT_W-1:0] exc_slot_o,
  output logic [RET_W-1:0]  squash_o
);
  logic [WIN_W-1:0]          win_q, win_d;
  logic [CNT_W-1:0]          thr_q;
  logic [RET_W:0][WIN_W-1:0] snap;
  logic [RET_W-1:0]          over, hit;

  ibd_snap_chain #(.RET_W(RET_W), .WIN_W(WIN_W)) i_chain (
    .win_i   (win_q),
    .valid_i (ret_valid_i),
    .ib_i    (ret_ib_i),
    .snap_o  (snap)
  );

  for (genvar k = 0; k < RET_W; k++) begin : g_cmp
    ibd_popcmp #(.WIN_W(WIN_W), .CNT_W(CNT_W)) i_popcmp (
      .win_i  (snap[k+1]),
      .thr_i  (thr_q),
      .over_o (over[k])
    );
  end

  assign hit = over & ret_valid_i;

  ibd_prio #(.RET_W(RET_W), .SLOT_W(SLOT_W)) i_prio (
    .hit_i       (hit),
    .valid_i     (ret_valid_i),
    .exc_valid_o (exc_valid_o),
    .exc_vec_o   (exc_vec_o),
    .exc_slot_o  (exc_slot_o),
    .squash_o    (squash_o)
  );

  // commit only through the flagged slot
  always_comb begin
    win_d = snap[RET_W];
    for (int k = 0; k < int'(RET_W); k++) begin
      if (exc_vec_o[k]) win_d = snap[k+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      thr_q <= CNT_W'(THR_RST);
    end else begin
      win_q <= win_we_i ? win_wdata_i : win_d;
      if (thr_we_i) thr_q <= thr_wdata_i;
    end
  end

  assign win_o = win_q;
  assign thr_o = thr_q;
endmodule

// File: rtl/ibd_checker.sv
module ibd_checker #(
  parameter int unsigned RET_W  = 3,
  parameter int unsigned WIN_W  = 32,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned SLOT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [RET_W-1:0]  ret_valid_i,
  input logic [RET_W-1:0]  ret_ib_i,
  input logic              win_we_i,
  input logic [WIN_W-1:0]  win_wdata_i,
  input logic              thr_we_i,
  input logic [CNT_W-1:0]  thr_wdata_i,
  input logic [WIN_W-1:0]  win_o,
  input logic [CNT_W-1:0]  thr_o,
  input logic              exc_valid_o,
  input logic [RET_W-1:0]  exc_vec_o,
  input logic [SLOT_W-1:0] exc_slot_o,
  input logic [RET_W-1:0]  squash_o
);
  assert_exc_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(exc_vec_o) && (exc_valid_o == (exc_vec_o != '0)));

  assert_exc_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> exc_vec_o[exc_slot_o]);

  assert_invalid_silent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((exc_vec_o | squash_o) & ~ret_valid_i) == '0);

  assert_squash_needs_exc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_o != '0) |-> exc_valid_o);

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_we_i && ret_valid_i == '0) |=> (win_o == $past(win_o)));

  assert_write_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_we_i |=> (win_o == $past(win_wdata_i)));

  assert_thr_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_we_i |=> (thr_o == $past(thr_wdata_i)));

  assert_commit_flagged_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o && !win_we_i) |=> (win_o[0] == $past(ret_ib_i[exc_slot_o])));
endmodule

bind ib_density_mon ibd_checker #(
  .RET_W(RET_W), .WIN_W(WIN_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
) i_ibd_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .ret_valid_i(ret_valid_i), .ret_ib_i(ret_ib_i),
  .win_we_i(win_we_i), .win_wdata_i(win_wdata_i), .thr_we_i(thr_we_i),
  .thr_wdata_i(thr_wdata_i), .win_o(win_o), .thr_o(thr_o),
  .exc_valid_o(exc_valid_o), .exc_vec_o(exc_vec_o), .exc_slot_o(exc_slot_o),
  .squash_o(squash_o)
);

// File: tb/test_ib_density_mon.sv
module test_ib_density_mon;
  localparam int RET_W = 3, WIN_W = 32, CNT_W = 6, SLOT_W = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [RET_W-1:0]  ret_valid, ret_ib;
  logic              win_we, thr_we;
  logic [WIN_W-1:0]  win_wdata, win_o;
  logic [CNT_W-1:0]  thr_wdata, thr_o;
  logic              exc_valid;
  logic [RET_W-1:0]  exc_vec, squash;
  logic [SLOT_W-1:0] exc_slot;

  int n_cmp = 0, n_bad = 0;
  logic [WIN_W-1:0] m_win;
  logic [CNT_W-1:0] m_thr;

  always #10 clk = ~clk;

  ib_density_mon i_ib_density_mon (
    .clk_i(clk), .rst_ni(rst_ni), .ret_valid_i(ret_valid), .ret_ib_i(ret_ib),
    .win_we_i(win_we), .win_wdata_i(win_wdata), .thr_we_i(thr_we),
    .thr_wdata_i(thr_wdata), .win_o(win_o), .thr_o(thr_o),
    .exc_valid_o(exc_valid), .exc_vec_o(exc_vec), .exc_slot_o(exc_slot),
    .squash_o(squash)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [WIN_W-1:0] w);
    int c = 0;
    for (int i = 0; i < WIN_W; i++) c += int'(w[i]);
    return c;
  endfunction

  // one retire cycle against the arithmetic model; m_win updated afterwards
  task automatic retire(input logic [RET_W-1:0] v, input logic [RET_W-1:0] b,
                        input logic we, input logic [WIN_W-1:0] wd);
    logic [WIN_W-1:0] w, nxt;
    logic [RET_W-1:0] e_vec, e_sq;
    int e_slot;
    logic found;
    @(negedge clk);
    ret_valid = v; ret_ib = b; win_we = we; win_wdata = wd;
    w = m_win; nxt = m_win; found = 1'b0; e_vec = '0; e_sq = '0; e_slot = 0;
    for (int k = 0; k < RET_W; k++) begin
      if (v[k]) begin
        if (found) e_sq[k] = 1'b1;
        else begin
          w = {w[WIN_W-2:0], b[k]};
          nxt = w;
          if (popc(w) > int'(m_thr)) begin
            found = 1'b1; e_vec[k] = 1'b1; e_slot = k;
          end
        end
      end
    end
    #5;
    chk("R4/R5 exc_vec", 64'(exc_vec), 64'(e_vec));
    chk("R5/R9 exc_valid", 64'(exc_valid), 64'(found));
    chk("R5 squash", 64'(squash), 64'(e_sq));
    if (found) chk("R5 exc_slot", 64'(exc_slot), 64'(e_slot));
    @(posedge clk); #1;
    m_win = we ? wd : nxt;
    chk(we ? "R7 write wins" : "R2/R3/R6 window", 64'(win_o), 64'(m_win));
    ret_valid = '0; win_we = 1'b0;
  endtask

  task automatic load_win(input logic [WIN_W-1:0] wd);
    retire('0, '0, 1'b1, wd);
  endtask

  task automatic set_thr(input logic [CNT_W-1:0] t);
    @(negedge clk);
    thr_we = 1'b1; thr_wdata = t;
    @(posedge clk); #1;
    thr_we = 1'b0;
    m_thr = t;
    chk("R8 threshold", 64'(thr_o), 64'(t));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    ret_valid = '0; ret_ib = '0; win_we = 1'b0; win_wdata = '0;
    thr_we = 1'b0; thr_wdata = '0;
    m_win = '0; m_thr = 6'd10;
    #35;
    chk("R1 reset win", 64'(win_o), 64'(0));
    chk("R1 reset thr", 64'(thr_o), 64'(10));
    chk("R1 reset exc", 64'(exc_valid), 64'(0));
    rst_ni = 1'b1;
    @(posedge clk); #1;

    // R2 ordering: slot 0 enters first
    retire(3'b111, 3'b100, 1'b0, '0);
    chk("R2 order", 64'(win_o[2:0]), 64'(3'b001));
    retire(3'b111, 3'b001, 1'b0, '0);
    chk("R2 order second", 64'(win_o[5:0]), 64'(6'b001100));

    // sweep: preload near threshold, low or high placement, all masks and bits
    for (int t = 9; t <= 11; t++) begin
      set_thr(CNT_W'(t));
      for (int pc = t - 2; pc <= t + 1; pc++) begin
        for (int hi = 0; hi < 2; hi++) begin
          for (int v = 0; v < 8; v++) begin
            for (int b = 0; b < 8; b++) begin
              logic [WIN_W-1:0] pat;
              pat = (WIN_W'(1) << pc) - 1;
              if (hi != 0) pat = pat << (WIN_W - pc);
              load_win(pat);
              retire(RET_W'(v), RET_W'(b), 1'b0, '0);
            end
          end
        end
      end
    end

    // R4 extremes: limit 0 fires on one branch, limit WIN_W never fires
    set_thr(6'd0);
    load_win('0);
    retire(3'b111, 3'b010, 1'b0, '0);
    set_thr(6'd32);
    load_win('1);
    retire(3'b111, 3'b111, 1'b0, '0);

    // R7 write with simultaneous retire
    set_thr(6'd10);
    load_win(32'h0000_0003);
    retire(3'b111, 3'b111, 1'b1, 32'hA5A5_0F0F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule